// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the seven-cycle bus sequence that takes a processor core into an exception handler. The same sequence serves the software break instruction, maskable interrupts and non-maskable interrupts. Once started with an entry kind and a snapshot of the program counter, stack pointer and status byte, it issues one bus access per cycle. It reads two throwaway bytes at the program counter, pushes the counter and the status byte onto the stack page, then fetches a 16-bit handler address from a vector and loads it as the new program counter.

The vector is not fixed by the entry kind. The sequencer looks at a live non-maskable-pending input at the end of the fifth cycle. If that input is high, the fetch goes to the non-maskable vector, even when the sequence started as a break or a maskable entry. The steps already taken keep the behaviour of the original kind: a break still advances the counter by two and still pushes its status with the break bit set. A maskable request arriving during a break changes nothing visible, because both kinds share one vector. At the end the disable bit is set in the status output. An acknowledge pulse tells the detection logic that its pending non-maskable request was taken.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `nmi_ack_o` are 0 and `rw_o` is 1 (read).
- R2: Entry kind is coded on `kind_i` as 0 = break, 1 = maskable, 2 = non-maskable, 3 = maskable. A start accepted while idle makes the next cycle cycle 1. Cycles 1 and 2 are reads, at the program counter and then at the counter after cycle 1. Only a break increments the counter after each of these two cycles.
- R3: Cycles 3 and 4 write the counter's high byte and then its low byte to address 0x0100 + stack pointer. The stack pointer decrements (mod 256) after each write.
- R4: Cycle 5 writes the status byte to 0x0100 + stack pointer and decrements the stack pointer. Bit 4 of the written byte is 1 for a break and 0 otherwise; the other bits come from `psr_i`.
- R5: The non-maskable vector is used when the kind is non-maskable, or when `nmi_pend_i` is high in cycle 5. A request that goes high only in cycle 6 or 7 does not change the vector.
- R6: Cycles 6 and 7 read the vector low byte and then the high byte, at 0xFFFA/0xFFFB for the non-maskable vector and 0xFFFE/0xFFFF otherwise.
- R7: A break whose vector is taken over still gets both counter increments and still pushes bit 4 as 1.
- R8: `done_o` is high in cycle 7 only. After it, `busy_o` is 0 and `pc_o` = {high byte, low byte} read in cycles 7 and 6. `sp_o` is the start value minus 3, and `psr_o` is `psr_i` with bit 2 set.
- R9: `nmi_ack_o` is high in cycle 7 exactly when the non-maskable vector was used.
- R10: `start_i` while busy is ignored; the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an entry sequence (idle only) |
| kind_i | input | 2 | Entry kind: 0 break, 1/3 maskable, 2 non-maskable |
| pc_i | input | 16 | Program counter at start |
| sp_i | input | 8 | Stack pointer at start |
| psr_i | input | 8 | Status byte at start |
| nmi_pend_i | input | 1 | Live non-maskable pending flag |
| bus_rdata_i | input | 8 | Read data for the current cycle's address |
| busy_o | output | 1 | Sequence in progress |
| addr_o | output | 16 | Bus address |
| rw_o | output | 1 | 1 read, 0 write |
| wdata_o | output | 8 | Write data |
| sp_o | output | 8 | Current stack pointer |
| pc_o | output | 16 | Program counter, handler address after done |
| psr_o | output | 8 | Status byte, disable bit set after done |
| done_o | output | 1 | Pulse in the final cycle |
| nmi_ack_o | output | 1 | Non-maskable request taken, in the final cycle |

## Verification
The assertions assume that read data is valid in the same cycle as its address, and that `start_i` is only meaningful while idle. They also assume that `nmi_pend_i` may change at any cycle but is sampled only at clock edges. The bench sweeps every entry kind against a request that rises in each of the seven cycles or never. It combines these with stack pointers that wrap through zero, a counter at the top of memory, and status bytes of all zeros and all ones. All inputs are driven half a cycle away from the sampling edge. The bench also pulses `start_i` in the middle of a running sequence.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  kind_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  psr_i,
  input  logic        nmi_pend_i,
  input  logic [7:0]  bus_rdata_i,
  output logic        busy_o,
  output logic [15:0] addr_o,
  output logic        rw_o,
  output logic [7:0]  wdata_o,
  output logic [7:0]  sp_o,
  output logic [15:0] pc_o,
  output logic [7:0]  psr_o,
  output logic        done_o,
  output logic        nmi_ack_o
);
  localparam logic [15:0] VEC_NMI   = 16'hFFFA;
  localparam logic [15:0] VEC_MASK  = 16'hFFFE;
  localparam logic [7:0]  STACK_HI  = 8'h01;

  logic [2:0]  step;
  logic        is_brk, is_nmi, use_nmi;
  logic [15:0] pc_r;
  logic [7:0]  sp_r, psr_r, vec_lo;
  logic [15:0] vec_base;

  assign vec_base  = use_nmi ? VEC_NMI : VEC_MASK;
  assign busy_o    = (step != 3'd0);
  assign done_o    = (step == 3'd7);
  assign nmi_ack_o = done_o & use_nmi;
  assign sp_o      = sp_r;
  assign pc_o      = pc_r;
  assign psr_o     = psr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= 3'd0;
      is_brk  <= 1'b0;
      is_nmi  <= 1'b0;
      use_nmi <= 1'b0;
      pc_r    <= 16'h0000;
      sp_r    <= 8'h00;
      psr_r   <= 8'h00;
      vec_lo  <= 8'h00;
    end else begin
      case (step)
        3'd0: if (start_i) begin
          step   <= 3'd1;
          is_brk <= (kind_i == 2'd0);
          is_nmi <= (kind_i == 2'd2);
          pc_r   <= pc_i;
          sp_r   <= sp_i;
          psr_r  <= psr_i;
        end
        3'd1, 3'd2: begin
          if (is_brk) pc_r <= pc_r + 16'd1;
          step <= step + 3'd1;
        end
        3'd3, 3'd4: begin
          sp_r <= sp_r - 8'd1;
          step <= step + 3'd1;
        end
        3'd5: begin
          sp_r    <= sp_r - 8'd1;
          use_nmi <= is_nmi | nmi_pend_i;
          step    <= 3'd6;
        end
        3'd6: begin
          vec_lo <= bus_rdata_i;
          step   <= 3'd7;
        end
        default: begin
          pc_r     <= {bus_rdata_i, vec_lo};
          psr_r[2] <= 1'b1;
          step     <= 3'd0;
        end
      endcase
    end
  end

  always_comb begin
    addr_o  = pc_r;
    rw_o    = 1'b1;
    wdata_o = 8'h00;
    case (step)
      3'd3: begin addr_o = {STACK_HI, sp_r}; rw_o = 1'b0; wdata_o = pc_r[15:8]; end
      3'd4: begin addr_o = {STACK_HI, sp_r}; rw_o = 1'b0; wdata_o = pc_r[7:0]; end
      3'd5: begin addr_o = {STACK_HI, sp_r}; rw_o = 1'b0; wdata_o = {psr_r[7:5], is_brk, psr_r[3:0]}; end
      3'd6: addr_o = vec_base;
      3'd7: addr_o = vec_base | 16'h0001;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic [15:0] addr_o,
  input logic        rw_o,
  input logic [7:0]  sp_o,
  input logic        done_o,
  input logic        nmi_ack_o
);
  // R3
  stack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rw_o) |=> (sp_o == $past(sp_o) - 8'd1));
  // R3
  write_on_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_o |-> (busy_o && addr_o[15:8] == 8'h01));
  // R6
  vec_hi_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (addr_o[15:3] == 13'h1FFF && addr_o[1:0] == 2'b11 && rw_o));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  // R9
  ack_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack_o |-> done_o);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [15:0] pc_i = 16'h0;
  logic [7:0]  sp_i = 8'h0;
  logic [7:0]  psr_i = 8'h0;
  logic        nmi_pend_i = 1'b0;
  logic [7:0]  bus_rdata_i;
  logic        busy_o, rw_o, done_o, nmi_ack_o;
  logic [15:0] addr_o, pc_o;
  logic [7:0]  wdata_o, sp_o, psr_o;
  int tests = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut (.*);

  function automatic logic [7:0] mem(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h78;
      16'hFFFB: return 8'h56;
      16'hFFFE: return 8'h34;
      16'hFFFF: return 8'h12;
      default:  return a[7:0] ^ 8'hA5;
    endcase
  endfunction
  assign bus_rdata_i = mem(addr_o);

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_case(input int kind, input logic [15:0] pc, input logic [7:0] sp,
                          input logic [7:0] psr, input int h, input bit poke);
    logic brk, nmi;
    logic [15:0] pushed, vec;
    logic [7:0] stat;
    brk    = (kind == 0);
    nmi    = (kind == 2) || (h >= 1 && h <= 5);
    pushed = brk ? pc + 16'd2 : pc;
    vec    = nmi ? 16'h5678 : 16'h1234;
    stat   = {psr[7:5], brk, psr[3:0]};
    @(negedge clk);
    start_i = 1'b1; kind_i = 2'(kind); pc_i = pc; sp_i = sp; psr_i = psr;
    @(posedge clk);
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      if (c == h) nmi_pend_i = 1'b1;
      start_i = (poke && c == 3);
      if (start_i) begin kind_i = 2'd1; pc_i = 16'hBEEF; sp_i = 8'h40; end
      case (c)
        1: begin chk("R2 c1 addr", addr_o, pc); chk("R2 c1 rw", rw_o, 1); end
        2: begin chk(brk ? "R7/R2 c2 addr" : "R2 c2 addr", addr_o, brk ? 16'(pc + 16'd1) : pc);
                 chk("R2 c2 rw", rw_o, 1); end
        3: begin chk("R3 c3 addr", addr_o, {8'h01, sp}); chk("R3 c3 rw", rw_o, 0);
                 chk(brk ? "R7 hi push" : "R3 hi push", wdata_o, pushed[15:8]); end
        4: begin chk("R3 c4 addr", addr_o, {8'h01, 8'(sp - 8'd1)}); chk("R3 c4 rw", rw_o, 0);
                 chk(brk ? "R7 lo push" : "R3 lo push", wdata_o, pushed[7:0]); end
        5: begin chk("R4 c5 addr", addr_o, {8'h01, 8'(sp - 8'd2)}); chk("R4 c5 rw", rw_o, 0);
                 chk(brk ? "R7/R4 status" : "R4 status", wdata_o, stat); end
        6: begin chk("R5/R6 c6 addr", addr_o, nmi ? 16'hFFFA : 16'hFFFE); chk("R6 c6 rw", rw_o, 1);
                 chk("R8 no done c6", done_o, 0); end
        default: begin chk("R5/R6 c7 addr", addr_o, nmi ? 16'hFFFB : 16'hFFFF);
                 chk("R8 done c7", done_o, 1); chk("R9 ack", nmi_ack_o, nmi); end
      endcase
    end
    @(negedge clk);
    start_i = 1'b0; nmi_pend_i = 1'b0;
    chk(poke ? "R10 busy end" : "R8 busy end", busy_o, 0);
    chk("R8 pc", pc_o, vec);
    chk("R8 sp", sp_o, 8'(sp - 8'd3));
    chk("R8 psr", psr_o, psr | 8'h04);
    chk("R8 done low", done_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 rw", rw_o, 1);
    chk("R1 ack", nmi_ack_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int h = 0; h <= 7; h++)
        for (int p = 0; p < 2; p++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 2; f++)
              run_case(k, p ? 16'hFFFF : 16'h12FF, s ? 8'hFD : 8'h02,
                       f ? 8'hFF : 8'h00, h, (h == 2 && s == 1));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule